// File: doc/BRIEF.md
# Signed 32-by-16 Iterative Divider with Condition Flags

This block divides a signed 32-bit dividend, supplied as an upper and a lower 16-bit word, by a signed 16-bit divisor. It returns a 16-bit quotient, a 16-bit remainder and four condition flags (negative, zero, overflow, carry) as an instruction execution unit of a 16-bit processor expects them. Operands are taken in on a start pulse. The block reports `busy` while it works and gives a single-cycle `done` when the results are valid. The results stay on the outputs until the next operation is accepted.

Internally the operands are turned into magnitudes and a restoring shift-subtract loop makes one quotient bit per cycle. The signs are applied afterwards. The FSM has five named states. `IDLE` waits for work. `LOAD` forms the magnitudes and checks for a zero divisor and for a quotient that is certain to be too large; it exits to `DONE` (short path) or to `STEP`. `STEP` runs 16 iterations and exits to `SIGN`. `SIGN` applies the signs, catches overflow that shows up only in the final quotient magnitude, and exits to `DONE`. `DONE` pulses `done`, then goes to `IDLE`, or to `LOAD` if a new start is present.

Top module: `sdiv32by16`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. The operands present at that edge are the ones divided. A start pulse or operand change while `busy` is high has no effect on that operation's results.
- R2: For a nonzero divisor with a representable quotient, the quotient is the true quotient truncated toward zero. The remainder is dividend minus quotient times divisor, so a nonzero remainder has the sign of the dividend (34/-5 gives -6 rem 4; -34/5 gives -6 rem -4).
- R3: A zero divisor gives flags N=0, Z=1, V=1, C=1 and takes the short path.
- R4: A true quotient outside -32768..32767 gives V=1, C=0, Z=0, with N equal to the XOR of the dividend sign bit and the divisor sign bit.
- R5: A quotient of exactly -32768 (for example 1073741824/-32768) is a normal result with no overflow. -32768/-1 overflows.
- R6: On a normal result V=0 and C=0, N equals quotient bit 15, and Z is 1 exactly when the quotient is zero (-1/3 gives quotient 0, remainder -1, Z=1).
- R7: Overflow that appears only in the final quotient magnitude is caught: -65536/-2 and 1073709056/32767 overflow, while -65535/-2 gives 32767 rem -1.
- R8: Counting the clock edge that samples start as edge 0, `done` is high after edge 1 when the divisor is zero or when the upper 16 bits of the dividend magnitude are at least the divisor magnitude. Otherwise `done` is high after edge 18. `done` lasts one cycle and `busy` is high from edge 0 until `done`.
- R9: Quotient, remainder and flags stay unchanged from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division when not busy |
| dvd_hi | input | 16 | Dividend upper word |
| dvd_lo | input | 16 | Dividend lower word |
| dvs | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quo | output | 16 | Quotient (zero when V is set) |
| rem | output | 16 | Remainder (zero when V is set) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (divide by zero) |

## Verification
Each result is due either 2 or 19 bench cycles after the cycle in which start is driven. The bench predicts which one from the operand magnitudes alone. The driver stamps every expected item with its start cycle and due latency. The monitor samples on the falling edge whenever `done` is high and compares the latency, the flags and, when V is clear, the quotient and remainder. After each result the outputs are sampled again three cycles later to confirm that they were held.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STEP,
        ST_SIGN,
        ST_DONE
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_mag.sv
// Splits signed operands into sign and magnitude, flags the short-path cases.
module sdiv_mag #(
    parameter int W = 16,
    localparam int DW = 2 * W
) (
    input  logic [DW-1:0] dd,
    input  logic [W-1:0]  dr,
    output logic          dd_neg,
    output logic          dr_neg,
    output logic [DW-1:0] dd_mag,
    output logic [W-1:0]  dr_mag,
    output logic          dr_zero,
    output logic          early_ovf
);
    always_comb begin
        dd_neg    = dd[DW-1];
        dr_neg    = dr[W-1];
        dd_mag    = dd_neg ? (~dd + 1'b1) : dd;
        dr_mag    = dr_neg ? (~dr + 1'b1) : dr;
        dr_zero   = (dr == '0);
        early_ovf = (dd_mag[DW-1:W] >= dr_mag);
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring shift-subtract iteration.
module sdiv_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] part_in,
    input  logic         bit_in,
    input  logic [W-1:0] dr_mag,
    output logic [W-1:0] part_out,
    output logic         q_bit
);
    logic [W:0] wide;
    logic [W:0] diff;
    always_comb begin
        wide     = {part_in, bit_in};
        diff     = wide - {1'b0, dr_mag};
        q_bit    = (wide >= {1'b0, dr_mag});
        part_out = q_bit ? diff[W-1:0] : wide[W-1:0];
    end
endmodule

// File: rtl/sdiv_fix.sv
// Applies signs, detects late overflow and builds the flags.
module sdiv_fix #(
    parameter int W = 16
) (
    input  logic         dd_neg,
    input  logic         dr_neg,
    input  logic         dr_zero,
    input  logic         early_ovf,
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output logic         f_n,
    output logic         f_z,
    output logic         f_v,
    output logic         f_c
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MAG = {1'b1, {(W-1){1'b0}}};

    logic res_neg;
    logic late_ovf;
    logic [W-1:0] q_sgn;

    always_comb begin
        res_neg  = dd_neg ^ dr_neg;
        late_ovf = res_neg ? (q_mag > NEG_MAG) : (q_mag > POS_MAX);
        q_sgn    = res_neg ? (~q_mag + 1'b1) : q_mag;
        if (dr_zero) begin
            q_out = '0; r_out = '0;
            f_n = 1'b0; f_z = 1'b1; f_v = 1'b1; f_c = 1'b1;
        end else if (early_ovf || late_ovf) begin
            q_out = '0; r_out = '0;
            f_n = res_neg; f_z = 1'b0; f_v = 1'b1; f_c = 1'b0;
        end else begin
            q_out = q_sgn;
            r_out = dd_neg ? (~r_mag + 1'b1) : r_mag;
            f_n   = q_sgn[W-1];
            f_z   = (q_sgn == '0);
            f_v   = 1'b0;
            f_c   = 1'b0;
        end
    end
endmodule

// File: rtl/sdiv32by16.sv
module sdiv32by16 #(
    parameter int W = 16,
    localparam int DW = 2 * W,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dvd_hi,
    input  logic [W-1:0]  dvd_lo,
    input  logic [W-1:0]  dvs,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  quo,
    output logic [W-1:0]  rem,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    import sdiv_pkg::*;

    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    sdiv_state_e state_q, state_d;
    logic [DW-1:0] dd_q;
    logic [W-1:0]  dr_q;
    logic [W-1:0]  part_q;
    logic [W-1:0]  shq_q;
    logic [CW-1:0] cnt_q;

    logic          dd_neg, dr_neg, dr_zero, early_ovf;
    logic [DW-1:0] dd_mag;
    logic [W-1:0]  dr_mag;
    logic [W-1:0]  part_nx;
    logic          q_bit;
    logic [W-1:0]  q_fix, r_fix;
    logic          f_n, f_z, f_v, f_c;
    logic          take;

    sdiv_mag #(.W(W)) u_mag (
        .dd(dd_q), .dr(dr_q),
        .dd_neg(dd_neg), .dr_neg(dr_neg),
        .dd_mag(dd_mag), .dr_mag(dr_mag),
        .dr_zero(dr_zero), .early_ovf(early_ovf)
    );

    sdiv_step #(.W(W)) u_step (
        .part_in(part_q), .bit_in(shq_q[W-1]), .dr_mag(dr_mag),
        .part_out(part_nx), .q_bit(q_bit)
    );

    sdiv_fix #(.W(W)) u_fix (
        .dd_neg(dd_neg), .dr_neg(dr_neg),
        .dr_zero(dr_zero), .early_ovf(early_ovf),
        .q_mag(shq_q), .r_mag(part_q),
        .q_out(q_fix), .r_out(r_fix),
        .f_n(f_n), .f_z(f_z), .f_v(f_v), .f_c(f_c)
    );

    assign take = start && !busy;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: state_d = (dr_zero || early_ovf) ? ST_DONE : ST_STEP;
            ST_STEP: if (cnt_q == LAST_STEP) state_d = ST_SIGN;
            ST_SIGN: state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_LOAD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q == ST_LOAD) || (state_q == ST_STEP) || (state_q == ST_SIGN);
    assign done = (state_q == ST_DONE);

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dd_q   <= '0;
            dr_q   <= '0;
            part_q <= '0;
            shq_q  <= '0;
            cnt_q  <= '0;
            quo    <= '0;
            rem    <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
        end else begin
            if (take) begin
                dd_q <= {dvd_hi, dvd_lo};
                dr_q <= dvs;
            end
            unique case (state_q)
                ST_LOAD: begin
                    part_q <= dd_mag[DW-1:W];
                    shq_q  <= dd_mag[W-1:0];
                    cnt_q  <= '0;
                    if (dr_zero || early_ovf) begin
                        quo <= q_fix; rem <= r_fix;
                        flag_n <= f_n; flag_z <= f_z;
                        flag_v <= f_v; flag_c <= f_c;
                    end
                end
                ST_STEP: begin
                    part_q <= part_nx;
                    shq_q  <= {shq_q[W-2:0], q_bit};
                    cnt_q  <= cnt_q + 1'b1;
                end
                ST_SIGN: begin
                    quo <= q_fix; rem <= r_fix;
                    flag_n <= f_n; flag_z <= f_z;
                    flag_v <= f_v; flag_c <= f_c;
                end
                default: ;
            endcase
        end
    end

    // R6
    normal_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_v) |-> (!flag_c && flag_n == quo[W-1] && flag_z == (quo == '0)));
    // R3
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_c) |-> (flag_v && flag_z && !flag_n));
    // R4
    ovf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v && !flag_c) |-> !flag_z);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quo) && $stable(rem) && $stable({flag_n, flag_z, flag_v, flag_c})));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!done && !busy));
    // R8
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (part_q < dr_mag));
endmodule

// File: tb/sdiv32by16_tb.sv
module sdiv32by16_tb;
    typedef struct {
        logic [3:0]  flags;   // n z v c
        logic [15:0] q;
        logic [15:0] r;
        int          lat;
        int          scyc;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
    logic busy, done;
    logic [15:0] quo, rem;
    logic flag_n, flag_z, flag_v, flag_c;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pending = 0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdiv32by16 u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
        .busy(busy), .done(done), .quo(quo), .rem(rem),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor: pop and compare on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8", "done with no pending item");
            end else begin
                exp_t e;
                logic [3:0] got;
                e = sb.pop_front();
                got = {flag_n, flag_z, flag_v, flag_c};
                check(cyc - e.scyc == e.lat, "R8",
                      $sformatf("%s latency act=%0d exp=%0d", e.tag, cyc - e.scyc, e.lat));
                check(got == e.flags, e.tag,
                      $sformatf("flags act=%b exp=%b", got, e.flags));
                if (!e.flags[1])
                    check(quo == e.q && rem == e.r, e.tag,
                          $sformatf("q/r act=%0d/%0d exp=%0d/%0d",
                                    $signed(quo), $signed(rem), $signed(e.q), $signed(e.r)));
                pending--;
            end
        end
    end

    function automatic exp_t model(input logic [31:0] dd32, input logic [15:0] dr16);
        exp_t e;
        longint dd, dr, q, r, ad, adr;
        dd = longint'($signed(dd32));
        dr = longint'($signed(dr16));
        e.q = '0; e.r = '0;
        if (dr == 0) begin
            e.flags = 4'b0111; e.lat = 2;
        end else begin
            q = dd / dr;
            r = dd % dr;
            ad = (dd < 0) ? -dd : dd;
            adr = (dr < 0) ? -dr : dr;
            e.lat = ((ad >> 16) >= adr) ? 2 : 19;
            if (q > 32767 || q < -32768) begin
                e.flags = {dd32[31] ^ dr16[15], 3'b010};
            end else begin
                e.q = q[15:0]; e.r = r[15:0];
                e.flags = {q < 0, q == 0, 2'b00};
            end
        end
        return e;
    endfunction

    // driver: push expectation, pulse start, optionally disturb, wait, check hold
    task automatic run(input logic [31:0] dd, input logic [15:0] dr, input string tag,
                       input bit disturb = 1'b0);
        exp_t e;
        logic [37:0] snap;
        e = model(dd, dr);
        e.tag = tag;
        @(negedge clk);
        while (busy) @(negedge clk);
        dvd_hi = dd[31:16]; dvd_lo = dd[15:0]; dvs = dr;
        start = 1'b1;
        e.scyc = cyc;
        sb.push_back(e);
        pending++;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R1: start and new operands while busy must not alter the result
            repeat (3) @(negedge clk);
            dvd_hi = 16'h1234; dvd_lo = 16'h5678; dvs = 16'h0007;
            if (busy) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (pending > 0) @(negedge clk);
        snap = {quo, rem, flag_n, flag_z, flag_v, flag_c, busy, done};
        repeat (3) @(negedge clk);
        // R9: outputs held after done
        check(snap[37:2] == {quo, rem, flag_n, flag_z, flag_v, flag_c} && !busy && !done,
              "R9", $sformatf("hold act=%h exp=%h", {quo, rem, flag_n, flag_z, flag_v, flag_c},
                              snap[37:2]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && quo == 0 && rem == 0 &&
              {flag_n, flag_z, flag_v, flag_c} == 4'b0, "reset",
              $sformatf("act busy=%b done=%b q=%h exp all zero", busy, done, quo));
        // R2 quadrants and truncation
        run(32'd34, 16'd5, "R2");
        run(32'd34, -16'sd5, "R2");
        run(-32'sd34, 16'd5, "R2");
        run(-32'sd34, -16'sd5, "R2");
        run(32'd4, 16'd3, "R2");
        run(32'd4, -16'sd3, "R2");
        // R6 zero quotient cases
        run(32'd2, 16'd3, "R6");
        run(-32'sd1, 16'd3, "R6");
        run(-32'sd2, -16'sd3, "R6");
        run(-32'sd3, -16'sd3, "R6");
        // R3 zero divisor
        run(32'd0, 16'd0, "R3");
        run(32'd1, 16'd0, "R3");
        run(-32'sd1, 16'd0, "R3");
        // R5 most negative quotient
        run(32'd1073741824, 16'h8000, "R5");
        run(32'd715849728, -16'sd21846, "R5");
        run(32'd1073774591, 16'h8000, "R5");
        run(-32'sd32768, -16'sd1, "R5");
        run(-32'sd32767, -16'sd1, "R5");
        // R7 late overflow
        run(-32'sd65536, -16'sd2, "R7");
        run(-32'sd65535, -16'sd2, "R7");
        run(-32'sd65534, -16'sd2, "R7");
        run(32'h3FFF8000, 16'd32767, "R7");
        run(-32'sd1073741823, 16'd32767, "R7");
        run(32'd715871574, -16'sd21846, "R7");
        // R4 big dividend overflow, N from operand signs
        run(32'h7FFFFFFF, 16'd1, "R4");
        run(32'h7FFFFFFF, -16'sd1, "R4");
        run(32'h80000000, 16'd2, "R4");
        run(32'h80000000, -16'sd1, "R4");
        // R1 disturbance while busy
        run(32'd1000000, 16'd777, "R1", 1'b1);
        run(-32'sd123456, 16'd99, "R1", 1'b1);
        // R2/R4/R6/R7 mixed patterns from an LCG
        seed = 32'hACE1_2468;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] d;
            seed = seed * 32'd1664525 + 32'd1013904223;
            d = seed[31:16] >> (i % 8);
            run({seed[15:0] >> (i % 12), seed[31:16] ^ seed[15:0]}, d, "R2");
        end
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule